// File: doc/BRIEF.md
# Carry-Save Tree Multiplier with Signed/Unsigned Select

This block multiplies two N-bit operands and returns the full 2N-bit product. It forms every AND partial product, reduces the resulting matrix in parallel carry-save stages until two rows remain, and adds those rows once in a carry-lookahead adder. The number of reduction stages grows with the logarithm of N. With the default N of 8 there are four stages.

A single select input chooses between unsigned and two's-complement operands. In two's-complement mode the partial products that involve exactly one operand's top bit are inverted. A one is also placed in column N and in column 2N-1. Every matrix entry then has positive weight, so both modes share one reduction tree and one final adder. The product is held in a register with a synchronous, active-high reset. It appears on the clock edge after the operands and the select are sampled.

Top module: `wt_mult`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `prod` becomes all zeros after that edge, whatever the operands and the select are.
- R2: `prod` changes only at a rising edge of `clk`. After the edge it shows the product of the operands and select sampled at that edge, and no input change between edges alters it.
- R3: With `sgn_mode` = 0, `prod` equals the unsigned product of `a_in` and `b_in`, as a 2N-bit unsigned value.
- R4: With `sgn_mode` = 1, `prod` read as a 2N-bit two's-complement value equals the product of `a_in` and `b_in`, each read as an N-bit two's-complement value.
- R5: The extreme operands give exact results. For N=8: unsigned 255 x 255 = 0xFE01. Signed -128 x -128 = 0x4000. Signed -128 x 127 = 0xC080. Signed -1 x -1 = 0x0001.
- R6: If either operand is zero, `prod` is zero in both modes.
- R7: With `sgn_mode` = 1 and both operands nonzero, bit 2N-1 of `prod` equals the XOR of bit N-1 of `a_in` and bit N-1 of `b_in`.
- R8: If bit N-1 is clear in both operands, `prod` is the same in both settings of `sgn_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The product register updates on the rising edge. |
| rst | input | 1 | Synchronous, active-high reset. Clears the product register. |
| a_in | input | N | First operand. |
| b_in | input | N | Second operand. |
| sgn_mode | input | 1 | 0 selects unsigned operands. 1 selects two's-complement operands. |
| prod | output | 2N | Registered 2N-bit product. |

## Verification
The bench builds the block with N = 8. At that size the full operand space is only 65,536 pairs, so every pair is applied in both modes, one pair per clock, and each result is compared against a product computed arithmetically. This sweep reaches every pattern of inverted bits and correction constants, and every carry path through the tree and the lookahead groups. Directed cases around reset and register timing come first, along with the extreme operands and the zero operands.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Row count left after s carry-save stages, starting from n rows.
  // Each stage maps three rows to two; one or two leftover rows pass through.
  function automatic int rows_after(input int n, input int s);
    int r;
    r = n;
    for (int i = 0; i < s; i++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // Number of stages needed to bring n rows down to two.
  function automatic int csa_stages(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/wt_ppgen.sv
module wt_ppgen #(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0]        a,
  input  logic [N-1:0]        b,
  input  logic                sgn,
  output logic [N-1:0][W-1:0] rows
);

  // Row j holds a_i & b_j at column i+j.
  // In signed mode an entry is inverted when exactly one index is the top index.
  // Correction ones go into free slots of row 0: column N and column 2N-1.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      rows[j] = '0;
      for (int i = 0; i < N; i++) begin
        rows[j][i+j] = (a[i] & b[j]) ^ (sgn & ((i == N-1) != (j == N-1)));
      end
    end
    rows[0][N]   = sgn;
    rows[0][W-1] = sgn;
  end

endmodule

// File: rtl/wt_csa.sv
module wt_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] cry
);

  // One 3:2 compressor per column. The sum stays in its column and the carry
  // moves one column left. The carry out of the top column falls outside the
  // 2N-bit product and is dropped.
  always_comb begin
    sum    = x ^ y ^ z;
    cry[0] = 1'b0;
    for (int i = 1; i < W; i++) begin
      cry[i] = (x[i-1] & y[i-1]) | (x[i-1] & z[i-1]) | (y[i-1] & z[i-1]);
    end
  end

endmodule

// File: rtl/wt_cla.sv
module wt_cla #(
  parameter int W = 16,
  localparam int WP = ((W + 3) / 4) * 4,
  localparam int NG = WP / 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  logic [WP-1:0] gen, prp, cin_bit, sp;
  logic [NG:0]   gcin;

  always_comb begin
    gen     = WP'(x) & WP'(y);
    prp     = WP'(x) ^ WP'(y);
    gcin[0] = 1'b0;
    cin_bit = '0;
    for (int q = 0; q < NG; q++) begin
      logic gg;
      logic gp;
      logic term;
      // Carry into each bit of the group, written out as sum of products.
      for (int k = 0; k < 4; k++) begin
        logic acc;
        term = gcin[q];
        for (int t = 0; t < k; t++) term = term & prp[4*q+t];
        acc = term;
        for (int m = 0; m < k; m++) begin
          term = gen[4*q+m];
          for (int t = m + 1; t < k; t++) term = term & prp[4*q+t];
          acc = acc | term;
        end
        cin_bit[4*q+k] = acc;
      end
      // Group generate and propagate feed the carry into the next group.
      gg = 1'b0;
      for (int m = 0; m < 4; m++) begin
        term = gen[4*q+m];
        for (int t = m + 1; t < 4; t++) term = term & prp[4*q+t];
        gg = gg | term;
      end
      gp = &prp[4*q +: 4];
      gcin[q+1] = gg | (gp & gcin[q]);
    end
    sp = prp ^ cin_bit;
    s  = sp[W-1:0];
  end

endmodule

// File: rtl/wt_mult.sv
module wt_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  input  logic           sgn_mode,
  output logic [2*N-1:0] prod
);

  localparam int W    = 2 * N;
  localparam int NSTG = wt_pkg::csa_stages(N);

  logic [N-1:0][W-1:0] pp;
  logic [W-1:0]        lvl [0:NSTG][0:N-1];
  logic [W-1:0]        sum_out;

  wt_ppgen #(.N(N)) u_ppgen (
    .a    (a_in),
    .b    (b_in),
    .sgn  (sgn_mode),
    .rows (pp)
  );

  for (genvar r = 0; r < N; r++) begin : g_lvl0
    assign lvl[0][r] = pp[r];
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam int RIN  = wt_pkg::rows_after(N, s);
    localparam int G    = RIN / 3;
    localparam int REM  = RIN - 3 * G;
    localparam int ROUT = 2 * G + REM;
    for (genvar g = 0; g < G; g++) begin : g_grp
      wt_csa #(.W(W)) u_csa (
        .x   (lvl[s][3*g]),
        .y   (lvl[s][3*g+1]),
        .z   (lvl[s][3*g+2]),
        .sum (lvl[s+1][2*g]),
        .cry (lvl[s+1][2*g+1])
      );
    end
    for (genvar k = 0; k < REM; k++) begin : g_pass
      assign lvl[s+1][2*G+k] = lvl[s][3*G+k];
    end
    for (genvar r = ROUT; r < N; r++) begin : g_zero
      assign lvl[s+1][r] = '0;
    end
  end

  wt_cla #(.W(W)) u_cla (
    .x (lvl[NSTG][0]),
    .y (lvl[NSTG][1]),
    .s (sum_out)
  );

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= sum_out;
  end

endmodule

// File: rtl/wt_mult_chk.sv
module wt_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   a_in,
  input logic [N-1:0]   b_in,
  input logic           sgn_mode,
  input logic [2*N-1:0] prod
);

  localparam int W = 2 * N;

  logic [W-1:0] ua, ub, sa, sb, uprod, sprod;
  assign ua    = W'(a_in);
  assign ub    = W'(b_in);
  assign sa    = {{N{a_in[N-1]}}, a_in};
  assign sb    = {{N{b_in[N-1]}}, b_in};
  assign uprod = ua * ub;
  assign sprod = W'($signed(sa) * $signed(sb));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> prod == '0);

  // R3
  unsigned_prod_chk: assert property (@(posedge clk) disable iff (rst)
    !sgn_mode |=> prod == $past(uprod));

  // R4
  signed_prod_chk: assert property (@(posedge clk) disable iff (rst)
    sgn_mode |=> prod == $past(sprod));

  // R6
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 || b_in == '0) |=> prod == '0);

  // R7
  sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (sgn_mode && a_in != '0 && b_in != '0)
      |=> prod[W-1] == ($past(a_in[N-1]) ^ $past(b_in[N-1])));

  // R8
  mode_neutral_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_in[N-1] && !b_in[N-1]) |=> prod == $past(uprod));

endmodule

bind wt_mult wt_mult_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_in     (b_in),
  .sgn_mode (sgn_mode),
  .prod     (prod)
);

// File: tb/wt_mult_test.sv
module wt_mult_test;

  localparam int N       = 8;
  localparam int W       = 2 * N;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 180000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] a_in = '0;
  logic [N-1:0] b_in = '0;
  logic         sgn_mode = 1'b0;
  logic [W-1:0] prod;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  wt_mult #(.N(N)) uut (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .sgn_mode (sgn_mode),
    .prod     (prod)
  );

  always #(CLK_PER / 2) clk = ~clk;

  function automatic logic [W-1:0] ref_prod(input logic [N-1:0] x, input logic [N-1:0] y,
                                            input logic sg);
    int xi;
    int yi;
    xi = int'(x);
    yi = int'(y);
    if (sg && x[N-1]) xi = xi - (1 << N);
    if (sg && y[N-1]) yi = yi - (1 << N);
    return W'(xi * yi);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] x, input logic [N-1:0] y, input logic sg,
                     input string req, input logic [W-1:0] exp);
    @(negedge clk);
    a_in = x; b_in = y; sgn_mode = sg;
    @(negedge clk);
    chk(req, prod, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d cycles expected=fewer", WDOG);
    finish_run();
  end

  initial begin
    logic [N-1:0] pa;
    logic [N-1:0] pb;
    logic         pm;
    logic [W-1:0] pexp;
    bit           have;

    // R1: reset holds the product at zero even with nonzero operands applied
    a_in = 8'd200; b_in = 8'd77; sgn_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", prod, '0);

    // R2: no path from inputs to output between edges
    rst = 1'b0; a_in = 8'd3; b_in = 8'd5;
    #1 chk("R2 before edge", prod, '0);
    @(negedge clk);
    chk("R2 after edge", prod, 16'd15);
    a_in = 8'd11; b_in = 8'd13;
    #1 chk("R2 held between edges", prod, 16'd15);
    @(negedge clk);
    chk("R2 next edge", prod, 16'd143);

    // R5: extreme operands
    run(8'hFF, 8'hFF, 1'b0, "R5 unsigned max", 16'hFE01);
    run(8'h80, 8'h80, 1'b1, "R5 signed min*min", 16'h4000);
    run(8'h80, 8'h7F, 1'b1, "R5 signed min*max", 16'hC080);
    run(8'hFF, 8'hFF, 1'b1, "R5 signed -1*-1", 16'h0001);

    // R6: a zero operand gives zero
    run(8'h00, 8'hAD, 1'b1, "R6 zero a signed", 16'h0000);
    run(8'h80, 8'h00, 1'b1, "R6 zero b signed", 16'h0000);
    run(8'h00, 8'hFF, 1'b0, "R6 zero a unsigned", 16'h0000);

    // R8: both top bits clear, the select makes no difference
    run(8'h55, 8'h3A, 1'b0, "R8 unsigned", 16'd4930);
    run(8'h55, 8'h3A, 1'b1, "R8 signed", 16'd4930);

    // R1: reset clears a nonzero product
    run(8'hC3, 8'h5E, 1'b0, "R3 before reset", 16'd18330);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears product", prod, '0);
    rst = 1'b0;

    // R3, R4, R7: every operand pair in both modes, one pair per clock
    have = 1'b0;
    pa = '0; pb = '0; pm = 1'b0; pexp = '0;
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < (1 << N); x++) begin
        for (int y = 0; y < (1 << N); y++) begin
          @(negedge clk);
          if (have) begin
            chk(pm ? "R4 signed sweep" : "R3 unsigned sweep", prod, pexp);
            if (pm && pa != '0 && pb != '0)
              chk("R7 sign bit", W'(prod[W-1]), W'(pa[N-1] ^ pb[N-1]));
          end
          a_in = N'(x); b_in = N'(y); sgn_mode = m[0];
          pa = N'(x); pb = N'(y); pm = m[0];
          pexp = ref_prod(N'(x), N'(y), m[0]);
          have = 1'b1;
        end
      end
    end
    @(negedge clk);
    chk("R4 signed sweep last", prod, pexp);

    finish_run();
  end

endmodule